// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital front end of a two-channel, 12-bit serial-input converter. A host shifts frames in over a three-wire serial port made of a serial clock, a data line and an active-low select. Each frame holds a two-bit channel address followed by a 12-bit straight-binary code. The block presents one 12-bit parallel code per channel. These codes stand in for the two analog outputs: 0x000 is zero scale, 0x800 is midscale and 0xFFF is full scale.

Writes are double-buffered. Shifting only changes a staging shift register. A separate active-low load input opens the output holding stages of the channels that the address bits currently staged select. A falling edge of load therefore transfers the staged code. If load is held low while bits are still arriving, the selected outputs follow the register bit by bit. An asynchronous active-low reset clears the staging register and both outputs.

Top module: `dacfe_top`

## Requirements
- R1: On each rising edge of `sclk` while `cs_n` is low, `sdi` enters bit 0 of a 14-bit staging register and all held bits move up by one. After 14 edges, the first bit sent sits in bit 13 and the second in bit 12.
- R2: The staged code is bits 11..0, straight binary, sent MSB first. A frame with address 2'b01 and code 0x800 gives `code_a` = 0x800 once loaded.
- R3: While `load_n` is high, shifting does not change `code_a` or `code_b`.
- R4: A high-to-low transition of `load_n` copies the staged code into every channel that the staged address selects.
- R5: While `load_n` is low, each selected channel output equals the staged code, so it changes after every shifted bit.
- R6: Rising edges of `sclk` while `cs_n` is high leave the staging register unchanged. A later load therefore yields the earlier frame.
- R7: Address decode uses the first bit sent as bit 1 and the second as bit 0. Address 2'b01 selects channel A only and 2'b10 selects channel B only.
- R8: Address 2'b11 updates both channels and 2'b00 updates neither.
- R9: `rst_n` low clears the staging register and both output codes to 0x000 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select gating the serial port |
| sdi | input | 1 | Serial data, address first then code MSB first |
| load_n | input | 1 | Active-low level load; low makes selected outputs transparent |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
A wrong staging bit shows up only when a load exposes it: either at the next falling `load_n`, or on the very next `sclk` edge when `load_n` is already low. Because of this, the bench compares both outputs after every shifted bit and after every load edge. A faulty decode changes the wrong channel on the first load of an affected address. Bits that leak through while `cs_n` is high are caught by the load that follows the ignored edges.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   localparam int ADDR_W = 2;
   localparam int NUM_CH = 2;
   typedef enum logic [ADDR_W-1:0] {
      SEL_NONE = 2'b00,
      SEL_A    = 2'b01,
      SEL_B    = 2'b10,
      SEL_BOTH = 2'b11
   } sel_e;
endpackage

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
   parameter int WIDTH = 14
) (
   input  logic             sclk,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             din,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 2) begin : g_bad
         $error("dacfe_shifter: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!en_n) q <= {q[WIDTH-2:0], din};
   end
endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
   import dacfe_pkg::*;
#(
   parameter bit BOTH_ON_ALL_ONES = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_CH-1:0] sel
);
   sel_e a;
   assign a = sel_e'(addr);

   generate
      if (BOTH_ON_ALL_ONES) begin : g_both
         always_comb begin
            unique case (a)
               SEL_A:    sel = 2'b01;
               SEL_B:    sel = 2'b10;
               SEL_BOTH: sel = 2'b11;
               default:  sel = 2'b00;
            endcase
         end
      end else begin : g_single
         always_comb begin
            unique case (a)
               SEL_A:   sel = 2'b01;
               SEL_B:   sel = 2'b10;
               default: sel = 2'b00;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
   parameter int WIDTH = 12
) (
   input  logic             rst_n,
   input  logic             open_n,
   input  logic             sel,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad
         $error("dacfe_hold: WIDTH must be positive");
      end
   endgenerate

   always_latch begin
      if (!rst_n)                q <= '0;
      else if (!open_n && sel)   q <= d;
   end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
   import dacfe_pkg::*;
#(
   parameter int CODE_W = 12
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              load_n,
   output logic [CODE_W-1:0] code_a,
   output logic [CODE_W-1:0] code_b
);
   localparam int FRAME_W = ADDR_W + CODE_W;

   generate
      if (CODE_W < 1) begin : g_bad
         $error("dacfe_top: CODE_W must be positive");
      end
   endgenerate

   logic [FRAME_W-1:0]      stage;
   logic [NUM_CH-1:0]       sel;
   logic [CODE_W-1:0]       ch_code [NUM_CH];

   dacfe_shifter #(.WIDTH(FRAME_W)) u_shift (
      .sclk (sclk),
      .rst_n(rst_n),
      .en_n (cs_n),
      .din  (sdi),
      .q    (stage)
   );

   dacfe_decode #(.BOTH_ON_ALL_ONES(1'b1)) u_dec (
      .addr(stage[FRAME_W-1 -: ADDR_W]),
      .sel (sel)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dacfe_hold #(.WIDTH(CODE_W)) u_hold (
         .rst_n (rst_n),
         .open_n(load_n),
         .sel   (sel[c]),
         .d     (stage[CODE_W-1:0]),
         .q     (ch_code[c])
      );
   end

   assign code_a = ch_code[0];
   assign code_b = ch_code[1];
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
   parameter int CODE_W = 12
) (
   input logic              sclk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sdi,
   input logic              load_n,
   input logic [CODE_W+1:0] stage,
   input logic [CODE_W-1:0] code_a,
   input logic [CODE_W-1:0] code_b
);
   AST_SELECT_GATES: assert property (@(posedge sclk) disable iff (!rst_n)
      cs_n |=> $stable(stage)); // R6
   AST_SHIFT_IN: assert property (@(posedge sclk) disable iff (!rst_n)
      !cs_n |=> (stage[0] == $past(sdi))); // R1
   AST_OPEN_A: assert property (@(posedge sclk) disable iff (!rst_n)
      (!load_n && stage[CODE_W]) |-> (code_a == stage[CODE_W-1:0])); // R5
   AST_OPEN_B: assert property (@(posedge sclk) disable iff (!rst_n)
      (!load_n && stage[CODE_W+1]) |-> (code_b == stage[CODE_W-1:0])); // R7
   AST_BOTH_MATCH: assert property (@(posedge sclk) disable iff (!rst_n)
      (!load_n && (stage[CODE_W+1:CODE_W] == 2'b11)) |-> (code_a == code_b)); // R8
   always @(negedge rst_n) begin
      #1;
      AST_RESET_ZERO: assert (rst_n || (code_a == '0 && code_b == '0)); // R9
   end
endmodule

bind dacfe_top dacfe_chk #(.CODE_W(CODE_W)) u_chk (
   .sclk  (sclk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .sdi   (sdi),
   .load_n(load_n),
   .stage (stage),
   .code_a(code_a),
   .code_b(code_b)
);

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;
   localparam int SCLK_PERIOD = 10;
   localparam int CW = 12;

   logic sclk = 0, rst_n = 0, cs_n = 1, sdi = 0, load_n = 1;
   logic [CW-1:0] code_a, code_b;

   dacfe_top #(.CODE_W(CW)) dut (
      .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
      .load_n(load_n), .code_a(code_a), .code_b(code_b)
   );

   int checks = 0, failures = 0;
   bit done = 0;
   logic [CW+1:0] msr = '0;
   logic [CW-1:0] ma = '0, mb = '0;

   function automatic logic [CW+1:0] shift_model(logic [CW+1:0] s, logic b);
      return {s[CW:0], b};
   endfunction

   task automatic apply_load();
      if (msr[CW])   ma = msr[CW-1:0];
      if (msr[CW+1]) mb = msr[CW-1:0];
   endtask

   task automatic check(string req, logic [CW-1:0] act_a, logic [CW-1:0] act_b);
      checks++;
      if (act_a !== ma || act_b !== mb) begin
         failures++;
         $display("FAIL %s: code_a=%h code_b=%h expected a=%h b=%h", req, act_a, act_b, ma, mb);
      end
   endtask

   task automatic bit_in(logic b);
      sdi = b;
      #(SCLK_PERIOD/2) sclk = 1;
      if (!cs_n) begin
         msr = shift_model(msr, b);
         if (!load_n) apply_load();
      end
      #(SCLK_PERIOD/2) sclk = 0;
      #1;
   endtask

   task automatic frame(logic [1:0] addr, logic [CW-1:0] code, string req);
      logic [CW+1:0] f;
      f = {addr, code};
      cs_n = 0;
      for (int i = CW+1; i >= 0; i--) begin
         bit_in(f[i]);
         check(req, code_a, code_b);
      end
      cs_n = 1;
      #1;
   endtask

   task automatic pulse_load(string req);
      load_n = 0;
      apply_load();
      #2 check(req, code_a, code_b);
      load_n = 1;
      #2 check(req, code_a, code_b);
   endtask

   initial begin
      #(SCLK_PERIOD*200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      #3 check("R9 reset", code_a, code_b);
      rst_n = 1;
      #2;
      // R2, R3, R4, R7: midscale to A, held until load
      frame(2'b01, 12'h800, "R3 held while load high");
      pulse_load("R2 R4 R7 midscale to A");
      frame(2'b10, 12'hFFF, "R3 held while load high");
      pulse_load("R7 full scale to B");
      // R8: both and neither
      frame(2'b11, 12'h001, "R3");
      pulse_load("R8 both channels");
      frame(2'b00, 12'hABC, "R3");
      pulse_load("R8 neither channel");
      // R6: edges with select high are ignored
      frame(2'b01, 12'h35A, "R1");
      for (int i = 0; i < 5; i++) bit_in(1'b0);
      pulse_load("R6 ignored edges while deselected");
      // R5: transparent while load low, follows bit by bit
      load_n = 0;
      #1 frame(2'b10, 12'h5A5, "R5 transparent follow");
      frame(2'b01, 12'h000, "R5 transparent follow");
      load_n = 1;
      #1 frame(2'b11, 12'h123, "R3");
      check("R3 after frame", code_a, code_b);
      // random mix
      for (int n = 0; n < 60; n++) begin
         logic [1:0] ad;
         logic [CW-1:0] cd;
         int mode;
         ad = 2'($urandom);
         cd = CW'($urandom);
         mode = int'($urandom % 3);
         if (mode == 1) begin
            load_n = 0;
            apply_load();
            #1;
         end
         frame(ad, cd, mode == 1 ? "R5 random transparent" : "R1 random frame");
         if (mode == 2) for (int k = 0; k < 3; k++) bit_in(1'($urandom));
         if (mode == 1) begin
            load_n = 1;
            #1;
         end else pulse_load("R4 random load");
      end
      // R9: asynchronous reset mid-operation
      rst_n = 0;
      msr = '0; ma = '0; mb = '0;
      #1 check("R9 async clear", code_a, code_b);
      rst_n = 1;
      #1 pulse_load("R9 staging cleared");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule